// File: doc/BRIEF.md
# Conditional Skip Operate Unit

This unit executes the skip-class operate word of a 12-bit accumulator machine. It receives a strobe together with the instruction word, the accumulator (AC), the link bit (L), the console switch register and the run flag. It then decides whether the program counter must step over the next word, and it updates AC and the run flag. It returns the new AC, link and run values, a done pulse, and a skip pulse that is aligned with done. The program counter is not part of this unit. It adds one extra word when it sees the skip pulse.

The work runs in a fixed order of phases, driven by a small state machine. From `ST_IDLE`, a strobe carrying a qualifying word moves to `ST_TEST`. A strobe with any other word leaves the machine in `ST_IDLE`. `ST_TEST` evaluates the selected conditions on the captured AC and link and always moves to `ST_CLEAR`. `ST_CLEAR` optionally zeroes AC and always moves to `ST_MERGE`. `ST_MERGE` optionally ORs the switch register into AC and optionally drops the run flag, then always moves to `ST_DONE`. `ST_DONE` raises done for one cycle and always returns to `ST_IDLE`.

Bits are numbered 0 (MSB, `instr[11]`) to 11 (LSB, `instr[0]`). AC bit 0 is `ac[W-1]`, the sign bit.

Top module: `skip_operate_unit`

## Requirements
- R1: A strobe is accepted only when word bits 0-2 are 111, bit 3 is 1 and bit 11 is 0. Any other word gives no done and no skip, and leaves `ac_out`, `link_out` and `run_out` unchanged.
- R2: The done pulse is high for exactly one cycle, in the fourth cycle after the clock edge that samples an accepted strobe. The skip output is never high while done is low.
- R3: When bit 8 is 0, the unit skips if any selected test is true. Bit 5 tests AC negative (AC bit 0 set), bit 6 tests AC equal to zero, and bit 7 tests L set.
- R4: When bit 8 is 1, each selected test is inverted (AC bit 0 clear, AC nonzero, L clear). The unit skips only if every selected inverted test holds.
- R5: With bit 8 set and bits 5-7 clear, the unit always skips. With bits 5-8 all clear, it never skips.
- R6: The tests use the AC value from before the bit 4 clear.
- R7: Bit 4 clears AC.
- R8: Bit 9 ORs the switch register into AC after the clear, so bits 4 and 9 together load the switch value.
- R9: Bit 10 clears the run flag. Without bit 10, the incoming run flag passes through unchanged.
- R10: The link bit passes through unchanged for every accepted word.
- R11: After reset, `ac_out`, `link_out`, `run_out`, `skip` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe qualifying `instr` and operands |
| instr | input | 12 | Instruction word, bit 0 = `instr[11]` |
| ac_in | input | W | Accumulator value to operate on |
| link_in | input | 1 | Link bit |
| sw_in | input | W | Console switch register (read only) |
| run_in | input | 1 | Current run flag |
| ac_out | output | W | Resulting accumulator |
| link_out | output | 1 | Resulting link bit |
| run_out | output | 1 | Resulting run flag |
| skip | output | 1 | Skip request pulse, aligned with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches several properties on every cycle. A skip appears only together with done. Done never lasts two cycles. A rejected strobe keeps the machine idle. AC is left alone during the test phase. The link bit and a dropped run flag stay put while an operation is in flight.

The condition logic is exercised only by the bench's vector scenarios. These cover OR and inverted-AND sensing, the test-before-clear ordering, the clear-then-OR ordering, the halt and pass-through cases, and the exact done latency.

// File: rtl/skp_pkg.sv
package skp_pkg;

    localparam int IW = 12;

    // bit k of the word (0 = most significant) maps to instr[IW-1-k]
    localparam int P_OP_HI  = IW - 1;
    localparam int P_OP_LO  = IW - 3;
    localparam int P_CLASS  = IW - 4;
    localparam int P_CLR    = IW - 5;
    localparam int P_NEG    = IW - 6;
    localparam int P_ZERO   = IW - 7;
    localparam int P_LNK    = IW - 8;
    localparam int P_INV    = IW - 9;
    localparam int P_OSR    = IW - 10;
    localparam int P_HLT    = IW - 11;
    localparam int P_GRP    = IW - 12;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TEST  = 3'd1,
        ST_CLEAR = 3'd2,
        ST_MERGE = 3'd3,
        ST_DONE  = 3'd4
    } skp_state_e;

    typedef struct packed {
        logic clr;
        logic neg;
        logic zero;
        logic lnk;
        logic inv;
        logic osr;
        logic hlt;
    } skp_ctl_t;

endpackage

// File: rtl/skp_decode.sv
module skp_decode
    import skp_pkg::*;
(
    input  logic [IW-1:0] word,
    output logic          word_ok,
    output skp_ctl_t      ctl
);

    localparam int OPW = P_OP_HI - P_OP_LO + 1;

    logic op_match;

    always_comb begin
        op_match = &word[P_OP_HI:P_OP_LO];
        word_ok  = op_match && word[P_CLASS] && !word[P_GRP];
    end

    always_comb begin
        ctl.clr  = word[P_CLR];
        ctl.neg  = word[P_NEG];
        ctl.zero = word[P_ZERO];
        ctl.lnk  = word[P_LNK];
        ctl.inv  = word[P_INV];
        ctl.osr  = word[P_OSR];
        ctl.hlt  = word[P_HLT];
    end

    initial begin
        if (OPW != 3) $display("skp_decode: opcode field width %0d", OPW);
    end

endmodule

// File: rtl/skp_cond.sv
module skp_cond
    import skp_pkg::*;
#(
    parameter int W = 12
) (
    input  skp_ctl_t     ctl,
    input  logic [W-1:0] ac,
    input  logic         link,
    output logic         hit
);

    localparam int NT = 3;

    logic [NT-1:0] sel;
    logic [NT-1:0] raw;
    logic [NT-1:0] pass;

    always_comb begin
        sel = {ctl.neg, ctl.zero, ctl.lnk};
        raw = {ac[W-1], (ac == '0), link};
    end

    generate
        for (genvar i = 0; i < NT; i++) begin : g_test
            // in OR mode an unselected test contributes 0, in AND mode 1
            always_comb begin
                if (ctl.inv) pass[i] = !sel[i] || !raw[i];
                else         pass[i] =  sel[i] &&  raw[i];
            end
        end
    endgenerate

    always_comb begin
        hit = ctl.inv ? (&pass) : (|pass);
    end

endmodule

// File: rtl/skp_ctrl.sv
module skp_ctrl
    import skp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       word_ok,
    output skp_state_e state,
    output logic       load_en,
    output logic       test_en,
    output logic       clear_en,
    output logic       merge_en,
    output logic       done
);

    skp_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start && word_ok) nxt = ST_TEST;
            ST_TEST:  nxt = ST_CLEAR;
            ST_CLEAR: nxt = ST_MERGE;
            ST_MERGE: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load_en  = 1'b0;
        test_en  = 1'b0;
        clear_en = 1'b0;
        merge_en = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:  load_en  = start && word_ok;
            ST_TEST:  test_en  = 1'b1;
            ST_CLEAR: clear_en = 1'b1;
            ST_MERGE: merge_en = 1'b1;
            ST_DONE:  done     = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/skip_operate_unit.sv
module skip_operate_unit
    import skp_pkg::*;
#(
    parameter int W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] instr,
    input  logic [W-1:0]  ac_in,
    input  logic          link_in,
    input  logic [W-1:0]  sw_in,
    input  logic          run_in,
    output logic [W-1:0]  ac_out,
    output logic          link_out,
    output logic          run_out,
    output logic          skip,
    output logic          done
);

    skp_state_e state;
    logic       word_ok;
    skp_ctl_t   ctl_dec;
    skp_ctl_t   ctl_r;
    logic       load_en, test_en, clear_en, merge_en;
    logic       hit;
    logic       skip_r;
    logic [W-1:0] ac_r;
    logic [W-1:0] sw_r;
    logic       link_r;
    logic       run_r;

    skp_decode u_dec (
        .word    (instr),
        .word_ok (word_ok),
        .ctl     (ctl_dec)
    );

    skp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word_ok  (word_ok),
        .state    (state),
        .load_en  (load_en),
        .test_en  (test_en),
        .clear_en (clear_en),
        .merge_en (merge_en),
        .done     (done)
    );

    skp_cond #(.W(W)) u_cond (
        .ctl  (ctl_r),
        .ac   (ac_r),
        .link (link_r),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r  <= '0;
            ac_r   <= '0;
            sw_r   <= '0;
            link_r <= 1'b0;
            run_r  <= 1'b0;
            skip_r <= 1'b0;
        end else begin
            if (load_en) begin
                ctl_r  <= ctl_dec;
                ac_r   <= ac_in;
                sw_r   <= sw_in;
                link_r <= link_in;
                run_r  <= run_in;
                skip_r <= 1'b0;
            end
            if (test_en) skip_r <= hit;
            if (clear_en && ctl_r.clr) ac_r <= '0;
            if (merge_en) begin
                if (ctl_r.osr) ac_r  <= ac_r | sw_r;
                if (ctl_r.hlt) run_r <= 1'b0;
            end
        end
    end

    always_comb begin
        ac_out   = ac_r;
        link_out = link_r;
        run_out  = run_r;
        skip     = done && skip_r;
    end

endmodule

// File: rtl/skp_chk.sv
module skp_chk
    import skp_pkg::*;
#(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         word_ok,
    input skp_state_e   state,
    input logic [W-1:0] ac_out,
    input logic         link_out,
    input logic         run_out,
    input logic         skip,
    input logic         done
);

    // R2
    skip_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> done);

    // R2
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    reject_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !word_ok) |=> (state == ST_IDLE && !done));

    // R6
    test_keeps_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TEST) |=> $stable(ac_out));

    // R10
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(link_out));

    // R9
    run_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !run_out) |=> !run_out);

endmodule

bind skip_operate_unit skp_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .word_ok  (word_ok),
    .state    (state),
    .ac_out   (ac_out),
    .link_out (link_out),
    .run_out  (run_out),
    .skip     (skip),
    .done     (done)
);

// File: tb/sim_skip_operate_unit.sv
module sim_skip_operate_unit;

    localparam int W  = 12;
    localparam int NV = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [11:0]   instr = '0;
    logic [W-1:0]  ac_in = '0;
    logic          link_in = 1'b0;
    logic [W-1:0]  sw_in = '0;
    logic          run_in = 1'b0;
    logic [W-1:0]  ac_out;
    logic          link_out, run_out, skip, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    skip_operate_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .ac_in(ac_in), .link_in(link_in), .sw_in(sw_in), .run_in(run_in),
        .ac_out(ac_out), .link_out(link_out), .run_out(run_out),
        .skip(skip), .done(done)
    );

    // {instr, ac, link, sw, run, exp_ac, exp_skip, exp_run}
    localparam logic [51:0] VEC [0:NV-1] = '{
        {12'o7500, 12'o4000, 1'b0, 12'o0000, 1'b1, 12'o4000, 1'b1, 1'b1}, // R3 neg
        {12'o7500, 12'o3777, 1'b0, 12'o0000, 1'b1, 12'o3777, 1'b0, 1'b1}, // R3
        {12'o7440, 12'o0000, 1'b1, 12'o0000, 1'b1, 12'o0000, 1'b1, 1'b1}, // R3 zero
        {12'o7440, 12'o0001, 1'b0, 12'o0000, 1'b1, 12'o0001, 1'b0, 1'b1}, // R3
        {12'o7420, 12'o0005, 1'b1, 12'o0000, 1'b1, 12'o0005, 1'b1, 1'b1}, // R3 link
        {12'o7460, 12'o0007, 1'b0, 12'o0000, 1'b1, 12'o0007, 1'b0, 1'b1}, // R3 or
        {12'o7510, 12'o3777, 1'b0, 12'o0000, 1'b1, 12'o3777, 1'b1, 1'b1}, // R4
        {12'o7510, 12'o4000, 1'b1, 12'o0000, 1'b1, 12'o4000, 1'b0, 1'b1}, // R4
        {12'o7450, 12'o0000, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b1}, // R4
        {12'o7570, 12'o0012, 1'b0, 12'o0000, 1'b1, 12'o0012, 1'b1, 1'b1}, // R4 all
        {12'o7570, 12'o0012, 1'b1, 12'o0000, 1'b1, 12'o0012, 1'b0, 1'b1}, // R4
        {12'o7410, 12'o1234, 1'b1, 12'o0000, 1'b1, 12'o1234, 1'b1, 1'b1}, // R5
        {12'o7400, 12'o7777, 1'b1, 12'o0000, 1'b1, 12'o7777, 1'b0, 1'b1}, // R5
        {12'o7640, 12'o0005, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b1}, // R6
        {12'o7650, 12'o0005, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b1, 1'b1}, // R6
        {12'o7600, 12'o1234, 1'b1, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b1}, // R7
        {12'o7404, 12'o0101, 1'b0, 12'o1010, 1'b1, 12'o1111, 1'b0, 1'b1}, // R8
        {12'o7604, 12'o7070, 1'b1, 12'o0123, 1'b1, 12'o0123, 1'b0, 1'b1}, // R8
        {12'o7402, 12'o0055, 1'b0, 12'o0000, 1'b1, 12'o0055, 1'b0, 1'b0}, // R9
        {12'o7406, 12'o0001, 1'b1, 12'o0002, 1'b1, 12'o0003, 1'b0, 1'b0}, // R9
        {12'o7400, 12'o0042, 1'b0, 12'o0000, 1'b0, 12'o0042, 1'b0, 1'b0}  // R9
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // drives one strobe at a negedge; returns edges to done and skip seen at done
    task automatic issue(input logic [11:0] w, input logic [W-1:0] a, input logic l,
                         input logic [W-1:0] s, input logic r,
                         output int lat, output logic sk, output bit early_skip);
        instr = w; ac_in = a; link_in = l; sw_in = s; run_in = r;
        start = 1'b1;
        lat = 0; sk = 1'b0; early_skip = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (skip && !done) early_skip = 1'b1;
            if (done) begin
                sk = skip;
                break;
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        int lat;
        logic sk;
        bit es;
        logic [W-1:0] held_ac;
        logic held_l, held_r;
        bit saw_done;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk(ac_out == '0 && link_out == 1'b0 && run_out == 1'b0 && !skip && !done,
            "R11", {ac_out, link_out, run_out, skip, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            issue(VEC[v][51:40], VEC[v][39:28], VEC[v][27], VEC[v][26:15], VEC[v][14],
                  lat, sk, es);
            chk(lat == 4, "R2 latency", lat, 4);
            chk(!es, "R2 skip without done", es, 0);
            chk(sk == VEC[v][1], "R3/R4/R5/R6 skip", sk, VEC[v][1]);
            chk(ac_out == VEC[v][13:2], "R6/R7/R8 ac", ac_out, VEC[v][13:2]);
            chk(run_out == VEC[v][0], "R9 run", run_out, VEC[v][0]);
            chk(link_out == VEC[v][27], "R10 link", link_out, VEC[v][27]);
            @(negedge clk);
            chk(!done && !skip, "R2 pulse width", {done, skip}, 0);
        end

        // R1: rejected words leave outputs untouched and give no done
        held_ac = ac_out; held_l = link_out; held_r = run_out;
        foreach (VEC[i]) begin
            if (i > 2) break;
            instr = (i == 0) ? 12'o7001 : (i == 1) ? 12'o7441 : 12'o5440;
            ac_in = 12'o7654; link_in = ~held_l; sw_in = 12'o7777; run_in = ~held_r;
            start = 1'b1;
            saw_done = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                start = 1'b0;
                if (done || skip) saw_done = 1'b1;
            end
            chk(!saw_done, "R1 no done", saw_done, 0);
            chk(ac_out == held_ac && link_out == held_l && run_out == held_r,
                "R1 outputs held", {ac_out, link_out, run_out}, {held_ac, held_l, held_r});
        end

        // R5 always-skip with link set and AC negative
        issue(12'o7410, 12'o4000, 1'b1, 12'o0000, 1'b1, lat, sk, es);
        chk(sk == 1'b1, "R5 unconditional", sk, 1);
        @(negedge clk);

        // R11 reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        chk(ac_out == '0 && !link_out && !run_out && !done && !skip,
            "R11 re-reset", {ac_out, link_out, run_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule